// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block sits on the memory side of an asynchronous DRAM strobe bus and watches the active-low row strobe, column strobe, write enable and output enable. A fast system clock samples all four. The block names each memory cycle from the order and spacing of the strobe edges alone. The cycle types it tells apart are read, early write, delayed write, read-modify-write, row-strobe-only refresh, column-before-row refresh, hidden refresh and self-refresh.

The block keeps its own 11-bit refresh row pointer for the refresh types that take their row from inside the device. It reports the row of every refresh on a pulse interface. It also drives a data-output enable that follows the drive rules of a real part.

It can be used as a passive bus monitor, or as the control core of a behavioural memory model. In the second use, a separate array model consumes the cycle reports and the output enable.

Strobes must not change on the same sample as each other, with one exception: a write-enable change may coincide with a column-strobe fall. All delays are counted in sampling edges.

Top module: `strobe_cycle_decoder`

## Requirements
- R1: After reset, `cyc_valid`, `rfsh_valid`, `cyc_indet`, `dout_en` and `self_active` are 0, `cyc_type` is 0, and the first refresh taken from the internal pointer is row 0.
- R2: Read. The row strobe falls and then the column strobe falls with write enable high. `dout_en` is 1 from the sample of the column fall while output enable is low. At the sample of the column rise, `cyc_valid` pulses with `cyc_type` = 1 and `dout_en` returns to 0.
- R3: Early write. Write enable is already low at the sample of the column fall. `dout_en` stays 0 for the whole access, and the column rise reports `cyc_type` = 2.
- R4: Delayed write. Write enable falls after the column fall, and output enable has been high on every sample since the column fall. The access reports `cyc_type` = 3 and `dout_en` stays 0.
- R5: Read-modify-write. Output enable is low, and write enable falls RMW_DLY or more samples after the column-fall sample. The access reports `cyc_type` = 4 with `cyc_indet` = 0, and `dout_en` stays 1 until the column rise.
- R6: Indeterminate. Output enable is low, and write enable falls 1 to RMW_DLY-1 samples after the column fall. `dout_en` drops at the write-enable fall sample, and the column rise reports `cyc_type` = 4 with `cyc_indet` = 1.
- R7: Page mode. Several column pulses inside one row-strobe low period each report their own access at their column rise. The closing row rise then reports nothing.
- R8: Row-strobe-only refresh. A row pulse during which the column strobe never fell reports `cyc_type` = 5 at the row-rise sample. On the same sample, `rfsh_valid` pulses with `rfsh_row` equal to `addr` as sampled at the row fall, and `dout_en` stays 0.
- R9: Column-before-row refresh. The column strobe is sampled low before the row strobe falls. At the row-fall sample the block reports `cyc_type` = 6 and pulses `rfsh_valid` with `rfsh_row` equal to the internal pointer. `addr` has no effect on that row.
- R10: Hidden refresh. After a read, the column strobe is held low while the row strobe rises and falls again. Each such row fall reports `cyc_type` = 7 with a pointer refresh, and `dout_en` stays 1. The final column rise reports the read (`cyc_type` = 1).
- R11: The internal pointer advances by one after every refresh taken from it, and wraps from 2047 to 0.
- R12: Self-refresh. The row strobe stays low for SELF_CYC samples after a column-before-row fall. `self_active` then rises and `cyc_type` = 8 is reported. Every SELF_STEP samples after that, a pointer refresh pulses. `self_active` drops at the sample of the row rise, and `dout_en` stays 0 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed address bus |
| cyc_valid | output | 1 | One-sample pulse: a cycle type is reported |
| cyc_type | output | 4 | Cycle code: 1 read, 2 early write, 3 delayed write, 4 read-modify-write, 5 row-only refresh, 6 column-before-row refresh, 7 hidden refresh, 8 self-refresh entry |
| cyc_indet | output | 1 | With `cyc_valid`: write-enable timing fit no window |
| rfsh_valid | output | 1 | One-sample pulse: a row was refreshed |
| rfsh_row | output | ROW_W | Row refreshed, valid with `rfsh_valid` |
| dout_en | output | 1 | Data pins would be driven |
| self_active | output | 1 | Self-refresh in progress |

## Verification
Every result is registered exactly once. The report of a strobe edge is therefore due at the first rising clock edge that samples that edge. The bench changes strobes on falling clock edges and reads outputs on the next falling edge, so each pulse is seen during the single cycle it lasts.

Delay-based results are reached by counting whole ticks from the sample of the column or row fall. These are the write-enable window of read-modify-write, the self-refresh entry and the self-refresh period. The bench checks the tick just before each threshold as well as the threshold tick itself.

// File: rtl/scd_pkg.sv
package scd_pkg;

    typedef enum logic [3:0] {
        CT_NONE = 4'd0,
        CT_READ = 4'd1,
        CT_EWR  = 4'd2,
        CT_DWR  = 4'd3,
        CT_RMW  = 4'd4,
        CT_ROR  = 4'd5,
        CT_CBR  = 4'd6,
        CT_HID  = 4'd7,
        CT_SELF = 4'd8
    } cyc_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROW,
        S_ACC,
        S_HOLD,
        S_HID,
        S_CBR,
        S_SELF,
        S_WAIT
    } st_t;

    typedef enum logic [2:0] {
        M_READ,
        M_EWR,
        M_DWR,
        M_RMW,
        M_IND
    } mode_t;

    function automatic cyc_t mode_to_cyc(mode_t m);
        case (m)
            M_EWR:   return CT_EWR;
            M_DWR:   return CT_DWR;
            M_RMW:   return CT_RMW;
            M_IND:   return CT_RMW;
            default: return CT_READ;
        endcase
    endfunction

endpackage

// File: rtl/scd_row_ctr.sv
module scd_row_ctr #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);
    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (step) row_d = row_q + ROW_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row = row_q;

    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && row_q == '1) |=> (row_q == '0)); // R11

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(row_q)); // R11

endmodule

// File: rtl/scd_tick_cnt.sv
module scd_tick_cnt #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                     cnt_d = W'(1);
        else if (inc && cnt_q != '1) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == W'(1))); // R12

endmodule

// File: rtl/strobe_cycle_decoder.sv
module strobe_cycle_decoder
    import scd_pkg::*;
#(
    parameter int ROW_W     = 11,
    parameter int RMW_DLY   = 3,
    parameter int SELF_CYC  = 10000,
    parameter int SELF_STEP = 6250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [ROW_W-1:0] addr,
    output logic             cyc_valid,
    output logic [3:0]       cyc_type,
    output logic             cyc_indet,
    output logic             rfsh_valid,
    output logic [ROW_W-1:0] rfsh_row,
    output logic             dout_en,
    output logic             self_active
);
    localparam int CNT_MAX0 = (SELF_CYC > SELF_STEP) ? SELF_CYC : SELF_STEP;
    localparam int CNT_MAX  = (CNT_MAX0 > RMW_DLY) ? CNT_MAX0 : RMW_DLY;
    localparam int CNT_W    = $clog2(CNT_MAX + 2);
    localparam logic [CNT_W-1:0] RMW_C  = CNT_W'(RMW_DLY);
    localparam logic [CNT_W-1:0] SELF_C = CNT_W'(SELF_CYC);
    localparam logic [CNT_W-1:0] STEP_C = CNT_W'(SELF_STEP);

    typedef struct packed {
        st_t              st;
        mode_t            mode;
        logic             oe_seen;
        logic             acc_any;
        logic [ROW_W-1:0] row;
        logic             ras_s;
        logic             cas_s;
        logic             we_s;
        logic             cyc_valid;
        cyc_t             cyc_type;
        logic             indet;
        logic             rfsh_valid;
        logic [ROW_W-1:0] rfsh_row;
        logic             dout_en;
        logic             self_act;
    } regs_t;

    regs_t            r_d, r_q;
    logic             cnt_clr, cnt_inc, ptr_step;
    logic [CNT_W-1:0] cnt_q;
    logic [ROW_W-1:0] ptr_q;

    scd_tick_cnt #(.W(CNT_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .cnt  (cnt_q)
    );

    scd_row_ctr #(.ROW_W(ROW_W)) u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .step (ptr_step),
        .row  (ptr_q)
    );

    logic ras_fall, ras_rise, we_fall, oe_now;
    assign ras_fall = r_q.ras_s & ~ras_n;
    assign ras_rise = ~r_q.ras_s & ras_n;
    assign we_fall  = r_q.we_s & ~we_n;
    assign oe_now   = r_q.oe_seen | ~oe_n;

    always_comb begin
        r_d            = r_q;
        r_d.ras_s      = ras_n;
        r_d.cas_s      = cas_n;
        r_d.we_s       = we_n;
        r_d.cyc_valid  = 1'b0;
        r_d.cyc_type   = CT_NONE;
        r_d.indet      = 1'b0;
        r_d.rfsh_valid = 1'b0;
        cnt_clr        = 1'b0;
        cnt_inc        = 1'b0;
        ptr_step       = 1'b0;

        case (r_q.st)
            S_IDLE: begin
                r_d.acc_any = 1'b0;
                if (ras_fall) begin
                    if (!r_q.cas_s) begin
                        r_d.st         = S_CBR;
                        cnt_clr        = 1'b1;
                        ptr_step       = 1'b1;
                        r_d.cyc_valid  = 1'b1;
                        r_d.cyc_type   = CT_CBR;
                        r_d.rfsh_valid = 1'b1;
                        r_d.rfsh_row   = ptr_q;
                    end else begin
                        r_d.st  = S_ROW;
                        r_d.row = addr;
                    end
                end
            end
            S_ROW: begin
                if (ras_n) begin
                    r_d.st = S_IDLE;
                    if (!r_q.acc_any) begin
                        r_d.cyc_valid  = 1'b1;
                        r_d.cyc_type   = CT_ROR;
                        r_d.rfsh_valid = 1'b1;
                        r_d.rfsh_row   = r_q.row;
                    end
                end else if (!cas_n) begin
                    r_d.st      = S_ACC;
                    r_d.acc_any = 1'b1;
                    r_d.oe_seen = ~oe_n;
                    r_d.mode    = we_n ? M_READ : M_EWR;
                    cnt_clr     = 1'b1;
                end
            end
            S_ACC: begin
                cnt_inc     = 1'b1;
                r_d.oe_seen = oe_now;
                if (we_fall && r_q.mode == M_READ) begin
                    if (!oe_now)           r_d.mode = M_DWR;
                    else if (cnt_q >= RMW_C) r_d.mode = M_RMW;
                    else                   r_d.mode = M_IND;
                end
                if (cas_n) begin
                    r_d.st        = S_ROW;
                    r_d.cyc_valid = 1'b1;
                    r_d.cyc_type  = mode_to_cyc(r_d.mode);
                    r_d.indet     = (r_d.mode == M_IND);
                end else if (ras_n) begin
                    r_d.st = S_HOLD;
                end
            end
            S_HOLD: begin
                if (cas_n) begin
                    r_d.st        = S_IDLE;
                    r_d.cyc_valid = 1'b1;
                    r_d.cyc_type  = mode_to_cyc(r_q.mode);
                    r_d.indet     = (r_q.mode == M_IND);
                end else if (!ras_n) begin
                    r_d.st         = S_HID;
                    ptr_step       = 1'b1;
                    r_d.cyc_valid  = 1'b1;
                    r_d.cyc_type   = CT_HID;
                    r_d.rfsh_valid = 1'b1;
                    r_d.rfsh_row   = ptr_q;
                end
            end
            S_HID: begin
                if (cas_n) begin
                    r_d.st        = S_WAIT;
                    r_d.cyc_valid = 1'b1;
                    r_d.cyc_type  = mode_to_cyc(r_q.mode);
                    r_d.indet     = (r_q.mode == M_IND);
                end else if (ras_n) begin
                    r_d.st = S_HOLD;
                end
            end
            S_WAIT: begin
                if (ras_n) r_d.st = S_IDLE;
            end
            S_CBR: begin
                if (ras_n) begin
                    r_d.st = S_IDLE;
                end else if (cnt_q >= SELF_C) begin
                    r_d.st        = S_SELF;
                    r_d.self_act  = 1'b1;
                    r_d.cyc_valid = 1'b1;
                    r_d.cyc_type  = CT_SELF;
                    cnt_clr       = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            S_SELF: begin
                if (ras_n) begin
                    r_d.st       = S_IDLE;
                    r_d.self_act = 1'b0;
                end else if (cnt_q >= STEP_C) begin
                    ptr_step       = 1'b1;
                    r_d.rfsh_valid = 1'b1;
                    r_d.rfsh_row   = ptr_q;
                    cnt_clr        = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            default: r_d.st = S_IDLE;
        endcase

        r_d.dout_en = (r_d.st == S_ACC || r_d.st == S_HOLD || r_d.st == S_HID)
                   && (r_d.mode == M_READ || r_d.mode == M_RMW)
                   && !oe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= S_IDLE;
            r_q.mode     <= M_READ;
            r_q.cyc_type <= CT_NONE;
            r_q.ras_s    <= 1'b1;
            r_q.cas_s    <= 1'b1;
            r_q.we_s     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cyc_valid   = r_q.cyc_valid;
    assign cyc_type    = r_q.cyc_type;
    assign cyc_indet   = r_q.indet;
    assign rfsh_valid  = r_q.rfsh_valid;
    assign rfsh_row    = r_q.rfsh_row;
    assign dout_en     = r_q.dout_en;
    assign self_active = r_q.self_act;

    AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ras_s && r_q.cas_s) |-> !dout_en); // R1

    AST_EWR_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_ACC && r_q.mode == M_EWR) |-> !dout_en); // R3

    AST_INDET_WITH_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_indet |-> (cyc_valid && cyc_type == 4'd4)); // R6

    AST_SELF_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        self_active |-> !dout_en); // R12

    AST_SELF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(self_active) |-> r_q.ras_s); // R12

    AST_ROR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_type == 4'd5) |-> (rfsh_valid && !dout_en)); // R8

endmodule

// File: tb/sim_strobe_cycle_decoder.sv
module sim_strobe_cycle_decoder;
    localparam int RW        = 11;
    localparam int RMW_DLY   = 3;
    localparam int SELF_CYC  = 10000;
    localparam int SELF_STEP = 6250;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [RW-1:0] addr = '0;
    logic          cyc_valid, cyc_indet, rfsh_valid, dout_en, self_active;
    logic [3:0]    cyc_type;
    logic [RW-1:0] rfsh_row;

    int checks = 0;
    int errors = 0;
    int exp_ptr = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    strobe_cycle_decoder #(
        .ROW_W(RW), .RMW_DLY(RMW_DLY), .SELF_CYC(SELF_CYC), .SELF_STEP(SELF_STEP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
        .cyc_indet(cyc_indet), .rfsh_valid(rfsh_valid), .rfsh_row(rfsh_row),
        .dout_en(dout_en), .self_active(self_active)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic int exp_type(bit ew, bit oe_low, int dly);
        if (ew)       return 2;
        if (dly == 0) return 1;
        if (!oe_low)  return 3;
        return 4;
    endfunction

    function automatic bit exp_indet(bit ew, bit oe_low, int dly);
        return !ew && oe_low && dly > 0 && dly < RMW_DLY;
    endfunction

    function automatic bit exp_drive_after_we(bit oe_low, int dly);
        return oe_low && dly >= RMW_DLY;
    endfunction

    function automatic int next_ptr(int p);
        return (p + 1) % 2048;
    endfunction

    // one column access inside an open row
    task automatic access(input bit ew, input bit oe_low, input int dly);
        if (ew) begin
            we_n = 1'b0;
            tick();
        end
        oe_n  = !oe_low;
        cas_n = 1'b0;
        tick();
        chk("R2 dout at column fall", dout_en, !ew && oe_low);
        if (!ew && dly > 0) begin
            repeat (dly - 1) tick();
            we_n = 1'b0;
            tick();
            chk("R5/R6 dout after WE fall", dout_en, exp_drive_after_we(oe_low, dly));
        end
        tick();
        cas_n = 1'b1;
        tick();
        chk("R2/R3/R4 report valid", cyc_valid, 1);
        chk("R2/R3/R4/R5 cycle type", cyc_type, exp_type(ew, oe_low, dly));
        chk("R6 indeterminate flag", cyc_indet, exp_indet(ew, oe_low, dly));
        chk("R2 dout off at column rise", dout_en, 0);
        we_n = 1'b1;
        oe_n = 1'b1;
        tick();
    endtask

    task automatic page(input int n);
        addr  = RW'($urandom);
        ras_n = 1'b0;
        tick();
        chk("R7 no report at row fall", cyc_valid, 0);
        for (int i = 0; i < n; i++)
            access($urandom % 4 == 0, $urandom % 2, $urandom % 6);
        ras_n = 1'b1;
        tick();
        chk("R7 no report at closing row rise", cyc_valid, 0);
        chk("R7 no refresh at closing row rise", rfsh_valid, 0);
    endtask

    task automatic ras_only(input logic [RW-1:0] row);
        addr  = row;
        ras_n = 1'b0;
        tick();
        addr = RW'($urandom);
        tick();
        ras_n = 1'b1;
        tick();
        chk("R8 report valid", cyc_valid, 1);
        chk("R8 cycle type", cyc_type, 5);
        chk("R8 refresh pulse", rfsh_valid, 1);
        chk("R8 refresh row", rfsh_row, row);
        chk("R8 dout stays off", dout_en, 0);
    endtask

    task automatic cbr();
        cas_n = 1'b0;
        tick();
        chk("R9 nothing at column fall", cyc_valid, 0);
        addr  = RW'($urandom);
        ras_n = 1'b0;
        tick();
        chk("R9 cycle type", cyc_type, 6);
        chk("R9 refresh pulse", rfsh_valid, 1);
        chk("R9 R11 refresh row from pointer", rfsh_row, exp_ptr);
        exp_ptr = next_ptr(exp_ptr);
        tick();
        ras_n = 1'b1;
        tick();
        cas_n = 1'b1;
        tick();
    endtask

    task automatic hidden(input int k);
        addr  = RW'($urandom);
        ras_n = 1'b0;
        tick();
        oe_n  = 1'b0;
        cas_n = 1'b0;
        tick();
        chk("R10 read drives", dout_en, 1);
        ras_n = 1'b1;
        tick();
        chk("R10 data held after row rise", dout_en, 1);
        chk("R10 no report at row rise", cyc_valid, 0);
        for (int i = 0; i < k; i++) begin
            ras_n = 1'b0;
            tick();
            chk("R10 hidden type", cyc_type, 7);
            chk("R10 hidden refresh row", rfsh_row, exp_ptr);
            chk("R10 data still driven", dout_en, 1);
            exp_ptr = next_ptr(exp_ptr);
            ras_n = 1'b1;
            tick();
        end
        cas_n = 1'b1;
        tick();
        chk("R10 read reported at column rise", cyc_type, 1);
        chk("R10 dout off", dout_en, 0);
        oe_n = 1'b1;
        tick();
    endtask

    task automatic self_refresh();
        cas_n = 1'b0;
        tick();
        ras_n = 1'b0;
        tick();
        chk("R12 entry refresh row", rfsh_row, exp_ptr);
        exp_ptr = next_ptr(exp_ptr);
        repeat (SELF_CYC - 1) tick();
        chk("R12 not yet self", self_active, 0);
        tick();
        chk("R12 self active", self_active, 1);
        chk("R12 self type", cyc_type, 8);
        repeat (SELF_STEP - 1) tick();
        chk("R12 no refresh before period", rfsh_valid, 0);
        tick();
        chk("R12 periodic refresh", rfsh_valid, 1);
        chk("R12 periodic refresh row", rfsh_row, exp_ptr);
        chk("R12 dout off in self", dout_en, 0);
        exp_ptr = next_ptr(exp_ptr);
        repeat (3) tick();
        ras_n = 1'b1;
        tick();
        chk("R12 self exit", self_active, 0);
        cas_n = 1'b1;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7341));
        repeat (3) tick();
        chk("R1 cyc_valid reset", cyc_valid, 0);
        chk("R1 rfsh_valid reset", rfsh_valid, 0);
        chk("R1 dout reset", dout_en, 0);
        chk("R1 self reset", self_active, 0);
        chk("R1 type reset", cyc_type, 0);
        rst_n = 1'b1;
        tick();
        cbr();                               // R1 first pointer row is 0

        addr = 11'h155;
        ras_n = 1'b0;
        tick();
        access(1'b0, 1'b1, 0);               // R2 read
        access(1'b1, 1'b0, 0);               // R3 early write
        access(1'b0, 1'b0, 2);               // R4 delayed write
        access(1'b0, 1'b1, RMW_DLY);         // R5 boundary
        access(1'b0, 1'b1, RMW_DLY - 1);     // R6 boundary
        access(1'b0, 1'b1, 1);               // R6
        ras_n = 1'b1;
        tick();
        chk("R7 page close silent", cyc_valid, 0);

        ras_only(11'h7FF);
        ras_only(11'h000);
        hidden(2);

        for (int i = 0; i < 300; i++) begin
            case ($urandom % 5)
                0: page(1 + $urandom % 3);
                1: ras_only(RW'($urandom));
                2: cbr();
                3: hidden(1 + $urandom % 2);
                default: repeat (1 + $urandom % 3) tick();
            endcase
        end

        // R11 wrap 2047 -> 0
        begin
            int n = 2048 - exp_ptr + 2;
            for (int i = 0; i < n; i++) cbr();
        end

        self_refresh();
        cbr();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule